// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This block maps a 16-bit virtual address onto a 19-bit physical address by reading one entry of a single-level page table that lives in physical memory. The upper 7 address bits select one of 128 pages of 512 bytes. The lower 9 bits pass through unchanged as the offset inside the page. The table starts at a base address held in a register. Only a write made while the core reports kernel mode can change that register.

Each accepted request produces exactly one 16-bit read on the memory port. The block then checks the returned entry against the access type and the privilege mode that applied when the request was accepted. It answers with either a physical address or one fault code. A page fault means the page has no backing frame. A protection fault means the entry forbids this access. Only one translation is in flight at a time, and the core sees this through a ready signal.

Top module: `page_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_rd_en is 0, base_wr_denied is 0, and the table base is 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. From the next cycle req_ready stays 0 until the cycle in which rsp_valid is 1, and in that cycle it is 1 again.
- R3: In the cycle after acceptance, mem_rd_en is 1 for exactly one cycle. mem_rd_addr is then the table base plus twice the page number req_vaddr[15:9], taken modulo 2^19.
- R4: rsp_valid is 1 for exactly one cycle, the cycle after the edge that samples mem_rd_valid high while a read is outstanding.
- R5: With no fault, rsp_fault is 2'b00 and rsp_paddr is {entry[9:0], vaddr[8:0]}.
- R6: If entry bit 10 (unmapped) is 1, the response is a page fault, rsp_fault = 2'b01, whatever the other flags are. Code 2'b11 never appears.
- R7: A store (req_kind[1] = 1, so both 2'b10 and 2'b11) needs entry bit 11 (writable). Without it the response is a protection fault, rsp_fault = 2'b10.
- R8: A fetch (req_kind = 2'b00) needs entry bit 12 (executable), or it gets rsp_fault = 2'b10. A load (req_kind = 2'b01) needs neither of these flags.
- R9: If entry bit 13 (kernel-only) is 1 and kernel_mode was 0 at acceptance, the response is rsp_fault = 2'b10. The mode is sampled when the request is accepted.
- R10: A base write while kernel_mode is 1 sets the base from the next cycle on. A base write while kernel_mode is 0 leaves the base unchanged and sets base_wr_denied to 1 for one cycle, the cycle after the write.
- R11: Entry bits 15:14 are reserved and affect neither the fault code nor the address. On any fault, rsp_paddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kernel_mode | input | 1 | 1 when the core runs in kernel mode |
| base_wr_en | input | 1 | Write strobe for the table base |
| base_wr_data | input | 19 | New table base address |
| base_wr_denied | output | 1 | Pulses after a base write was refused |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 16 | Virtual address |
| req_kind | input | 2 | 00 fetch, 01 load, 1x store |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 19 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |
| mem_rd_en | output | 1 | Entry read strobe |
| mem_rd_addr | output | 19 | Entry physical address |
| mem_rd_valid | input | 1 | Entry read data is valid |
| mem_rd_data | input | 16 | Entry read data |

## Verification
Results appear at fixed delays. The entry read strobe and its address appear one cycle after the accepting edge. The response appears one cycle after the edge that samples the returned entry. The refusal pulse appears one cycle after a user-mode base write. The bench drives every input on the falling edge and samples each result on the falling edge that follows the rising edge that should produce it. This lets it check both the value and the exact cycle. The memory side is answered after a chosen number of extra cycles, so the hold of req_ready low is checked across different latencies.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
   // flag positions inside the flag field that sits above the frame number
   localparam int FLG_UNMAPPED = 0;
   localparam int FLG_WRITE    = 1;
   localparam int FLG_EXEC     = 2;
   localparam int FLG_KONLY    = 3;
   localparam int FLG_USED     = 4;

   typedef enum logic [1:0] {
      FLT_NONE = 2'b00,
      FLT_PAGE = 2'b01,
      FLT_PROT = 2'b10
   } fault_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_ISSUE = 2'b01,
      ST_WAIT  = 2'b10
   } state_e;
endpackage

// File: rtl/pgx_base_reg.sv
module pgx_base_reg #(
   parameter int PA_W = 19
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            kernel_mode,
   input  logic            wr_en,
   input  logic [PA_W-1:0] wr_data,
   output logic [PA_W-1:0] base,
   output logic            denied
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base   <= '0;
         denied <= 1'b0;
      end else begin
         if (wr_en && kernel_mode) base <= wr_data;
         denied <= wr_en && !kernel_mode;
      end
   end
endmodule

// File: rtl/pgx_pte_check.sv
module pgx_pte_check
   import pgx_pkg::*;
#(
   parameter int PTE_W = 16,
   parameter int PPN_W = 10,
   parameter int OFF_W = 9,
   localparam int PA_W = PPN_W + OFF_W
) (
   input  logic [PTE_W-1:0] entry,
   input  logic [OFF_W-1:0] offset,
   input  logic [1:0]       kind,
   input  logic             kernel,
   output logic [PA_W-1:0]  paddr,
   output logic [1:0]       fault
);
   logic [FLG_USED-1:0] flags;
   logic                is_store;
   logic                is_fetch;

   assign flags    = entry[PPN_W +: FLG_USED];
   assign is_store = kind[1];
   assign is_fetch = (kind == 2'b00);

   generate
      if (PTE_W > PPN_W + FLG_USED) begin : g_rsv
         logic unused_rsv;
         assign unused_rsv = ^entry[PTE_W-1:PPN_W+FLG_USED];
      end
   endgenerate

   always_comb begin
      fault = FLT_NONE;
      paddr = '0;
      if (flags[FLG_UNMAPPED])
         fault = FLT_PAGE;
      else if (flags[FLG_KONLY] && !kernel)
         fault = FLT_PROT;
      else if (is_store && !flags[FLG_WRITE])
         fault = FLT_PROT;
      else if (is_fetch && !flags[FLG_EXEC])
         fault = FLT_PROT;
      else
         paddr = {entry[PPN_W-1:0], offset};
   end
endmodule

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
   import pgx_pkg::*;
#(
   parameter int VA_W = 16,
   parameter int PN_W = 7,
   parameter int PA_W = 19,
   localparam int OFF_W = VA_W - PN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_kind,
   input  logic             kernel_mode,
   input  logic [PA_W-1:0]  base,
   output logic             req_ready,
   output logic             mem_rd_en,
   output logic [PA_W-1:0]  mem_rd_addr,
   input  logic             mem_rd_valid,
   output logic [OFF_W-1:0] cap_off,
   output logic [1:0]       cap_kind,
   output logic             cap_kernel,
   input  logic [PA_W-1:0]  chk_paddr,
   input  logic [1:0]       chk_fault,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic [1:0]       rsp_fault
);
   state_e           state;
   logic [PA_W-1:0]  tbl_off;

   assign tbl_off   = {{(PA_W-PN_W-1){1'b0}}, req_vaddr[VA_W-1 -: PN_W], 1'b0};
   assign req_ready = (state == ST_IDLE);
   assign mem_rd_en = (state == ST_ISSUE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         mem_rd_addr <= '0;
         cap_off     <= '0;
         cap_kind    <= '0;
         cap_kernel  <= 1'b0;
         rsp_valid   <= 1'b0;
         rsp_paddr   <= '0;
         rsp_fault   <= FLT_NONE;
      end else begin
         rsp_valid <= 1'b0;
         case (state)
            ST_IDLE: if (req_valid) begin
               mem_rd_addr <= base + tbl_off;
               cap_off     <= req_vaddr[OFF_W-1:0];
               cap_kind    <= req_kind;
               cap_kernel  <= kernel_mode;
               state       <= ST_ISSUE;
            end
            ST_ISSUE: state <= ST_WAIT;
            ST_WAIT: if (mem_rd_valid) begin
               rsp_valid <= 1'b1;
               rsp_paddr <= chk_paddr;
               rsp_fault <= chk_fault;
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
   parameter int VA_W  = 16,
   parameter int PN_W  = 7,
   parameter int PPN_W = 10,
   parameter int PTE_W = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         kernel_mode,
   input  logic                         base_wr_en,
   input  logic [PPN_W+VA_W-PN_W-1:0]   base_wr_data,
   output logic                         base_wr_denied,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [VA_W-1:0]              req_vaddr,
   input  logic [1:0]                   req_kind,
   output logic                         rsp_valid,
   output logic [PPN_W+VA_W-PN_W-1:0]   rsp_paddr,
   output logic [1:0]                   rsp_fault,
   output logic                         mem_rd_en,
   output logic [PPN_W+VA_W-PN_W-1:0]   mem_rd_addr,
   input  logic                         mem_rd_valid,
   input  logic [PTE_W-1:0]             mem_rd_data
);
   localparam int OFF_W = VA_W - PN_W;
   localparam int PA_W  = PPN_W + OFF_W;

   generate
      if (PN_W < 1 || PN_W >= VA_W) begin : g_bad_pn
         $error("page number width must lie inside the virtual address");
      end
      if (PTE_W < PPN_W + pgx_pkg::FLG_USED) begin : g_bad_pte
         $error("entry too narrow for frame number and flags");
      end
      if (PA_W <= PN_W) begin : g_bad_pa
         $error("physical address too narrow to index the table");
      end
   endgenerate

   logic [PA_W-1:0]  base;
   logic [OFF_W-1:0] cap_off;
   logic [1:0]       cap_kind;
   logic             cap_kernel;
   logic [PA_W-1:0]  chk_paddr;
   logic [1:0]       chk_fault;

   pgx_base_reg #(.PA_W(PA_W)) u_base (
      .clk         (clk),
      .rst_n       (rst_n),
      .kernel_mode (kernel_mode),
      .wr_en       (base_wr_en),
      .wr_data     (base_wr_data),
      .base        (base),
      .denied      (base_wr_denied)
   );

   pgx_ctrl #(.VA_W(VA_W), .PN_W(PN_W), .PA_W(PA_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_vaddr    (req_vaddr),
      .req_kind     (req_kind),
      .kernel_mode  (kernel_mode),
      .base         (base),
      .req_ready    (req_ready),
      .mem_rd_en    (mem_rd_en),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_valid (mem_rd_valid),
      .cap_off      (cap_off),
      .cap_kind     (cap_kind),
      .cap_kernel   (cap_kernel),
      .chk_paddr    (chk_paddr),
      .chk_fault    (chk_fault),
      .rsp_valid    (rsp_valid),
      .rsp_paddr    (rsp_paddr),
      .rsp_fault    (rsp_fault)
   );

   pgx_pte_check #(.PTE_W(PTE_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_chk (
      .entry  (mem_rd_data),
      .offset (cap_off),
      .kind   (cap_kind),
      .kernel (cap_kernel),
      .paddr  (chk_paddr),
      .fault  (chk_fault)
   );
endmodule

// File: rtl/pgx_checker.sv
module pgx_checker #(
   parameter int PA_W = 19
) (
   input logic            clk,
   input logic            rst_n,
   input logic            kernel_mode,
   input logic            base_wr_en,
   input logic            base_wr_denied,
   input logic            req_valid,
   input logic            req_ready,
   input logic            mem_rd_en,
   input logic            mem_rd_valid,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_paddr,
   input logic [1:0]      rsp_fault
);
   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r3_read_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> mem_rd_en);

   a_r3_read_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   a_r4_rsp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(mem_rd_valid));

   a_r4_rsp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r6_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault != 2'b11));

   a_r11_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

   a_r10_deny_cause: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr_denied |-> $past(base_wr_en && !kernel_mode));
endmodule

bind page_xlate pgx_checker #(.PA_W(PPN_W+VA_W-PN_W)) u_pgx_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .kernel_mode    (kernel_mode),
   .base_wr_en     (base_wr_en),
   .base_wr_denied (base_wr_denied),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .mem_rd_en      (mem_rd_en),
   .mem_rd_valid   (mem_rd_valid),
   .rsp_valid      (rsp_valid),
   .rsp_paddr      (rsp_paddr),
   .rsp_fault      (rsp_fault)
);

// File: tb/page_xlate_test.sv
module page_xlate_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        kernel_mode = 1'b0;
   logic        base_wr_en = 1'b0;
   logic [18:0] base_wr_data = '0;
   logic        base_wr_denied;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        rsp_valid;
   logic [18:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic        mem_rd_en;
   logic [18:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [15:0] mem_rd_data = '0;

   int          checks = 0;
   int          errors = 0;
   logic [18:0] model_base = '0;
   bit          done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   page_xlate uut (
      .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode),
      .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
      .base_wr_denied(base_wr_denied),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_kind(req_kind),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
      check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
      check(mem_rd_en == 1'b0, "R1 mem_rd_en", 32'(mem_rd_en), 0);
      check(base_wr_denied == 1'b0, "R1 denied", 32'(base_wr_denied), 0);
   endtask

   task automatic base_write(input logic [18:0] val, input logic km, input string tag);
      @(negedge clk);
      base_wr_en = 1'b1; base_wr_data = val; kernel_mode = km;
      @(negedge clk);
      base_wr_en = 1'b0; base_wr_data = ~val;
      check(base_wr_denied == !km, {tag, " denied pulse"}, 32'(base_wr_denied), 32'(!km));
      if (km) model_base = val;
      @(negedge clk);
      check(base_wr_denied == 1'b0, {tag, " denied one cycle"}, 32'(base_wr_denied), 0);
   endtask

   task automatic xlate(input logic [15:0] va, input logic [1:0] kind, input logic km,
                        input logic [15:0] pte, input int lat,
                        input logic [18:0] exp_pa, input logic [1:0] exp_flt, input string tag);
      logic [18:0] ea;
      ea = model_base + {11'd0, va[15:9], 1'b0};
      @(negedge clk);
      kernel_mode = km; req_valid = 1'b1; req_vaddr = va; req_kind = kind;
      check(req_ready == 1'b1, {tag, " R2 ready before"}, 32'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0; kernel_mode = !km; req_vaddr = ~va; req_kind = ~kind;
      check(mem_rd_en == 1'b1, {tag, " R3 rd_en"}, 32'(mem_rd_en), 1);
      check(mem_rd_addr == ea, {tag, " R3 rd_addr"}, 32'(mem_rd_addr), 32'(ea));
      check(req_ready == 1'b0, {tag, " R2 busy"}, 32'(req_ready), 0);
      @(negedge clk);
      check(mem_rd_en == 1'b0, {tag, " R3 rd_en pulse"}, 32'(mem_rd_en), 0);
      for (int i = 0; i < lat; i++) @(negedge clk);
      check(req_ready == 1'b0 && rsp_valid == 1'b0, {tag, " R2 waiting"}, 32'({req_ready, rsp_valid}), 0);
      mem_rd_valid = 1'b1; mem_rd_data = pte;
      @(negedge clk);
      mem_rd_valid = 1'b0; mem_rd_data = ~pte;
      check(rsp_valid == 1'b1, {tag, " R4 rsp_valid"}, 32'(rsp_valid), 1);
      check(rsp_fault == exp_flt, {tag, " fault"}, 32'(rsp_fault), 32'(exp_flt));
      check(rsp_paddr == exp_pa, {tag, " paddr"}, 32'(rsp_paddr), 32'(exp_pa));
      check(req_ready == 1'b1, {tag, " R2 ready again"}, 32'(req_ready), 1);
      @(negedge clk);
      check(rsp_valid == 1'b0, {tag, " R4 rsp pulse"}, 32'(rsp_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      // R3 R5 at base 0: page 1010111, frame 1100110011, offset 100000101
      xlate({7'b1010111, 9'b100000101}, 2'b01, 1'b0, {6'b000000, 10'b1100110011}, 0,
            19'b1100110011100000101, 2'b00, "R5 load base0");
      base_write(19'h12340, 1'b1, "R10 kernel write");
      xlate({7'd5, 9'h1ff}, 2'b01, 1'b0, {6'b000000, 10'h2a5}, 2,
            {10'h2a5, 9'h1ff}, 2'b00, "R3 R5 load new base");
      // R7 stores
      xlate({7'd9, 9'h003}, 2'b10, 1'b0, {6'b000010, 10'h011}, 3,
            {10'h011, 9'h003}, 2'b00, "R7 store writable");
      xlate({7'd9, 9'h003}, 2'b10, 1'b0, {6'b000100, 10'h011}, 1,
            19'd0, 2'b10, "R7 store not writable");
      xlate({7'd9, 9'h004}, 2'b11, 1'b0, {6'b000101 ^ 6'b000001, 10'h011}, 0,
            19'd0, 2'b10, "R7 kind11 as store");
      // R8 fetch and load
      xlate({7'd64, 9'h080}, 2'b00, 1'b0, {6'b000010, 10'h3ff}, 0,
            19'd0, 2'b10, "R8 fetch not exec");
      xlate({7'd64, 9'h080}, 2'b00, 1'b0, {6'b000100, 10'h3ff}, 0,
            {10'h3ff, 9'h080}, 2'b00, "R8 fetch exec");
      xlate({7'd64, 9'h081}, 2'b01, 1'b0, {6'b000000, 10'h200}, 0,
            {10'h200, 9'h081}, 2'b00, "R8 load no flags");
      // R6 unmapped dominates
      xlate({7'd3, 9'h010}, 2'b01, 1'b1, {6'b000111, 10'h155}, 1,
            19'd0, 2'b01, "R6 unmapped page fault");
      xlate({7'd3, 9'h010}, 2'b10, 1'b0, {6'b001001, 10'h155}, 0,
            19'd0, 2'b01, "R6 unmapped over kernel-only");
      // R9 kernel-only
      xlate({7'd100, 9'h0aa}, 2'b01, 1'b0, {6'b001000, 10'h0f0}, 0,
            19'd0, 2'b10, "R9 user on kernel page");
      xlate({7'd100, 9'h0aa}, 2'b01, 1'b1, {6'b001000, 10'h0f0}, 0,
            {10'h0f0, 9'h0aa}, 2'b00, "R9 kernel on kernel page");
      // R11 reserved bits ignored
      xlate({7'd7, 9'h155}, 2'b10, 1'b0, {6'b110010, 10'h0c3}, 0,
            {10'h0c3, 9'h155}, 2'b00, "R11 reserved set");
      // R10 user write refused, base unchanged as seen on read address
      base_write(19'h00400, 1'b0, "R10 user write");
      xlate({7'd2, 9'h000}, 2'b01, 1'b0, {6'b000000, 10'h001}, 0,
            {10'h001, 9'h000}, 2'b00, "R10 base kept");
      // R3 wrap of entry address
      base_write(19'h7fff0, 1'b1, "R10 kernel write high");
      xlate({7'd127, 9'h1fe}, 2'b01, 1'b1, {6'b000000, 10'h3c3}, 4,
            {10'h3c3, 9'h1fe}, 2'b00, "R3 address wrap");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule